// File: doc/BRIEF.md
# Write-Triggered Transfer Launcher

This block lets software start a transfer by writing a descriptor, with no hardware event involved. It provides eight launch channels. Each channel is programmed with a descriptor slot index, a word index inside that slot, and an enable bit. The descriptor slots sit in a parameter memory that is reached over the configuration bus. Any bus master may write that memory, so the block watches every write on the bus.

A slot is 32 bytes, which is eight 32-bit words. The word address of word `w` in slot `e` is `BASE_WADDR + e*8 + w`. When a write lands exactly on the word that an enabled channel has chosen, that channel becomes pending. Pending channels are handed to the transfer engine one per cycle. Each hand-off is a one-cycle submit pulse that carries the channel number and its slot index.

Several channels may share one trigger word. In that case they are all raised and then served in ascending channel order. Suppose a channel is triggered again while it is still waiting and is not being served in that cycle. The second launch is not queued. A sticky per-channel missed flag is set instead. The parameter memory itself and the transfer engine are outside this block.

Top module: `quick_xfer_trigger`

## Requirements
- R1: After reset, `sub_valid` is 0, `missed` is 0, and every channel is disabled. A write to word address `BASE_WADDR` (slot 0, word 0) produces no submit.
- R2: Suppose an enabled channel has slot `e` and word `w`, and a write to word address `BASE_WADDR + e*8 + w` is sampled at clock edge k. Then `sub_valid` is high for one cycle after edge k+1, with `sub_chan` set to the channel number and `sub_entry` set to `e`.
- R3: A channel whose enable bit is 0 never submits, even when its trigger word is written.
- R4: Writes to the other seven words of the same slot, or to words of other slots, cause no submit and set no flag.
- R5: Suppose one write hits the trigger words of several channels. Each of those channels is submitted once, in ascending channel number, on consecutive cycles. The lowest channel appears after edge k+1.
- R6: Suppose a channel is triggered while it is pending and is not being submitted in that same cycle. Then `missed[channel]` is set and no extra submit is issued. If the channel is being submitted in that cycle, it is instead pended again and submitted once more.
- R7: `missed` bits stay set until the matching bit of `missed_clr` is high at a clock edge. They read 0 after that edge.
- R8: A map write sampled at edge k affects bus writes sampled from edge k+1 onward. A bus write sampled at the same edge k is compared against the previous mapping.
- R9: When `bus_wr_en` is 0, the value of `bus_wr_waddr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_wr_en | input | 1 | Load one channel's mapping |
| map_wr_chan | input | 3 | Channel to load |
| map_wr_enable | input | 1 | New enable bit |
| map_wr_entry | input | 7 | New descriptor slot index |
| map_wr_wsel | input | 3 | New trigger word index within the slot |
| bus_wr_en | input | 1 | A configuration-bus write is present this cycle |
| bus_wr_waddr | input | 14 | Word address of that write |
| missed_clr | input | 8 | Clear mask for the missed flags |
| sub_valid | output | 1 | Submit pulse |
| sub_chan | output | 3 | Channel being submitted |
| sub_entry | output | 7 | Slot index of the submitted channel |
| missed | output | 8 | Sticky per-channel missed-trigger flags |

## Verification
A wrong bit in the pending register shows up at the submit port within at most eight cycles. The symptom is a missing, extra or reordered submit, or a submit that comes out of order behind a higher channel. A broken address comparator shows up two edges after the offending write, either as a spurious pulse or as no pulse. The bench logs every submit with the cycle it appeared in and compares that log against the exact cycle and channel sequence expected. A missed-flag error is visible on `missed` one edge after the second trigger.

// File: rtl/qxt_pkg.sv
package qxt_pkg;
   localparam int QX_NCH     = 8;
   localparam int QX_ENTRY_W = 7;
   localparam int QX_WSEL_W  = 3;
   localparam int QX_WADDR_W = 14;
endpackage

// File: rtl/qxt_chan_map.sv
module qxt_chan_map #(
   parameter int NCH     = qxt_pkg::QX_NCH,
   parameter int ENTRY_W = qxt_pkg::QX_ENTRY_W,
   parameter int WSEL_W  = qxt_pkg::QX_WSEL_W,
   parameter int WADDR_W = qxt_pkg::QX_WADDR_W,
   parameter logic [WADDR_W-1:0] BASE_WADDR = '0,
   localparam int CH_W   = $clog2(NCH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          map_wr_en,
   input  logic [CH_W-1:0]               map_wr_chan,
   input  logic                          map_wr_enable,
   input  logic [ENTRY_W-1:0]            map_wr_entry,
   input  logic [WSEL_W-1:0]             map_wr_wsel,
   input  logic                          bus_wr_en,
   input  logic [WADDR_W-1:0]            bus_wr_waddr,
   output logic [NCH-1:0]                hit,
   output logic [NCH-1:0][ENTRY_W-1:0]   entry_tab
);
   localparam int OFS_W = ENTRY_W + WSEL_W;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic               en_q;
      logic [ENTRY_W-1:0] ent_q;
      logic [WSEL_W-1:0]  ws_q;
      logic [WADDR_W-1:0] trig_waddr;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            ent_q <= '0;
            ws_q  <= '0;
         end else if (map_wr_en && (map_wr_chan == CH_W'(c))) begin
            en_q  <= map_wr_enable;
            ent_q <= map_wr_entry;
            ws_q  <= map_wr_wsel;
         end
      end

      logic [OFS_W-1:0] ofs;
      assign ofs        = {ent_q, ws_q};
      assign trig_waddr = BASE_WADDR + WADDR_W'(ofs);
      assign hit[c]     = bus_wr_en && en_q && (bus_wr_waddr == trig_waddr);
      assign entry_tab[c] = ent_q;
   end
endmodule

// File: rtl/qxt_pend_arb.sv
module qxt_pend_arb #(
   parameter int NCH = qxt_pkg::QX_NCH,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  hit,
   input  logic [NCH-1:0]  missed_clr,
   output logic            grant_vld,
   output logic [CH_W-1:0] grant_idx,
   output logic [NCH-1:0]  grant,
   output logic [NCH-1:0]  pend_q,
   output logic [NCH-1:0]  missed
);
   logic [NCH-1:0] keep, pend_d, miss_new, missed_q;

   // lowest set bit wins: ascending channel order
   assign grant     = pend_q & (~pend_q + NCH'(1));
   assign grant_vld = |pend_q;
   assign keep      = pend_q & ~grant;
   assign miss_new  = hit & keep;
   assign pend_d    = keep | hit;

   always_comb begin
      grant_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (grant[i]) grant_idx = CH_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         missed_q <= '0;
      end else begin
         pend_q   <= pend_d;
         missed_q <= (missed_q & ~missed_clr) | miss_new;
      end
   end

   assign missed = missed_q;
endmodule

// File: rtl/quick_xfer_trigger.sv
module quick_xfer_trigger #(
   parameter int NCH     = qxt_pkg::QX_NCH,
   parameter int ENTRY_W = qxt_pkg::QX_ENTRY_W,
   parameter int WSEL_W  = qxt_pkg::QX_WSEL_W,
   parameter int WADDR_W = qxt_pkg::QX_WADDR_W,
   parameter logic [WADDR_W-1:0] BASE_WADDR = WADDR_W'(14'h1000),
   localparam int CH_W   = $clog2(NCH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_wr_en,
   input  logic [CH_W-1:0]    map_wr_chan,
   input  logic               map_wr_enable,
   input  logic [ENTRY_W-1:0] map_wr_entry,
   input  logic [WSEL_W-1:0]  map_wr_wsel,
   input  logic               bus_wr_en,
   input  logic [WADDR_W-1:0] bus_wr_waddr,
   input  logic [NCH-1:0]     missed_clr,
   output logic               sub_valid,
   output logic [CH_W-1:0]    sub_chan,
   output logic [ENTRY_W-1:0] sub_entry,
   output logic [NCH-1:0]     missed
);
   localparam longint SPAN  = longint'(1) << (ENTRY_W + WSEL_W);
   localparam longint SPACE = longint'(1) << WADDR_W;

   if (NCH < 2) begin : g_bad_nch
      $error("quick_xfer_trigger: NCH must be at least 2");
   end
   if (longint'(BASE_WADDR) + SPAN > SPACE) begin : g_bad_base
      $error("quick_xfer_trigger: descriptor space exceeds the address range");
   end

   logic [NCH-1:0]              hit, grant, pend_q;
   logic [NCH-1:0][ENTRY_W-1:0] entry_tab;
   logic                        grant_vld;
   logic [CH_W-1:0]             grant_idx;

   qxt_chan_map #(
      .NCH(NCH), .ENTRY_W(ENTRY_W), .WSEL_W(WSEL_W),
      .WADDR_W(WADDR_W), .BASE_WADDR(BASE_WADDR)
   ) u_map (
      .clk(clk), .rst_n(rst_n),
      .map_wr_en(map_wr_en), .map_wr_chan(map_wr_chan),
      .map_wr_enable(map_wr_enable), .map_wr_entry(map_wr_entry),
      .map_wr_wsel(map_wr_wsel),
      .bus_wr_en(bus_wr_en), .bus_wr_waddr(bus_wr_waddr),
      .hit(hit), .entry_tab(entry_tab)
   );

   qxt_pend_arb #(.NCH(NCH)) u_arb (
      .clk(clk), .rst_n(rst_n), .hit(hit), .missed_clr(missed_clr),
      .grant_vld(grant_vld), .grant_idx(grant_idx), .grant(grant),
      .pend_q(pend_q), .missed(missed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_valid <= 1'b0;
         sub_chan  <= '0;
         sub_entry <= '0;
      end else begin
         sub_valid <= grant_vld;
         sub_chan  <= grant_idx;
         sub_entry <= entry_tab[grant_idx];
      end
   end
endmodule

// File: rtl/qxt_checker.sv
module qxt_checker #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr_en,
   input logic [NCH-1:0]  missed_clr,
   input logic            sub_valid,
   input logic [CH_W-1:0] sub_chan,
   input logic [NCH-1:0]  missed,
   input logic [NCH-1:0]  pend
);
   // R2: every submit comes from a channel that was pending
   a_r2_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> (($past(pend) & (NCH'(1) << sub_chan)) != '0));

   // R5: no lower channel was pending when a channel was submitted
   a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> (($past(pend) & ((NCH'(1) << sub_chan) - NCH'(1))) == '0));

   // R7: missed flags only drop when cleared
   a_r7_missed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(missed) & ~$past(missed_clr) & ~missed) == '0));

   // R9: no new pending bit without a bus write
   a_r9_idle_no_new: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr_en) |-> ((pend & ~$past(pend)) == '0));
endmodule

bind quick_xfer_trigger qxt_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .missed_clr(missed_clr),
   .sub_valid(sub_valid), .sub_chan(sub_chan), .missed(missed),
   .pend(u_arb.pend_q)
);

// File: tb/quick_xfer_trigger_test.sv
`timescale 1ns/1ps
module quick_xfer_trigger_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_wr_en = 1'b0;
   logic [2:0]  map_wr_chan = '0;
   logic        map_wr_enable = 1'b0;
   logic [6:0]  map_wr_entry = '0;
   logic [2:0]  map_wr_wsel = '0;
   logic        bus_wr_en = 1'b0;
   logic [13:0] bus_wr_waddr = '0;
   logic [7:0]  missed_clr = '0;
   logic        sub_valid;
   logic [2:0]  sub_chan;
   logic [6:0]  sub_entry;
   logic [7:0]  missed;

   localparam int BASE = 14'h1000;

   quick_xfer_trigger uut (
      .clk(clk), .rst_n(rst_n),
      .map_wr_en(map_wr_en), .map_wr_chan(map_wr_chan),
      .map_wr_enable(map_wr_enable), .map_wr_entry(map_wr_entry),
      .map_wr_wsel(map_wr_wsel),
      .bus_wr_en(bus_wr_en), .bus_wr_waddr(bus_wr_waddr),
      .missed_clr(missed_clr),
      .sub_valid(sub_valid), .sub_chan(sub_chan), .sub_entry(sub_entry),
      .missed(missed)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   int log_n = 0;
   int log_ch  [0:31];
   int log_ent [0:31];
   int log_cyc [0:31];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n && sub_valid && log_n < 32) begin
         log_ch[log_n]  = int'(sub_chan);
         log_ent[log_n] = int'(sub_entry);
         log_cyc[log_n] = cyc;
         log_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic map_set(input int ch, input bit en, input int ent, input int ws);
      @(negedge clk);
      map_wr_en = 1'b1; map_wr_chan = 3'(ch); map_wr_enable = en;
      map_wr_entry = 7'(ent); map_wr_wsel = 3'(ws);
      @(negedge clk);
      map_wr_en = 1'b0;
   endtask

   task automatic bus_wr(input int waddr, output int wc);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_wr_waddr = 14'(waddr);
      @(negedge clk);
      wc = cyc;
      bus_wr_en = 1'b0;
   endtask

   task automatic expect_entry(input string req, input int idx, input int ch,
                               input int ent, input int c);
      chk(log_ch[idx] == ch, req, "submit channel", log_ch[idx], ch);
      chk(log_ent[idx] == ent, req, "submit entry", log_ent[idx], ent);
      chk(log_cyc[idx] == c, req, "submit cycle", log_cyc[idx], c);
   endtask

   task automatic t_reset;
      int wc;
      chk(sub_valid == 1'b0, "R1", "sub_valid after reset", int'(sub_valid), 0);
      chk(missed == 8'h00, "R1", "missed after reset", int'(missed), 0);
      log_n = 0;
      bus_wr(BASE, wc);
      idle(4);
      chk(log_n == 0, "R1", "submits from disabled default map", log_n, 0);
   endtask

   task automatic t_single;
      int wc;
      map_set(3, 1'b1, 5, 2);
      log_n = 0;
      bus_wr(BASE + 5*8 + 2, wc);
      idle(4);
      chk(log_n == 1, "R2", "single trigger submit count", log_n, 1);
      if (log_n >= 1) expect_entry("R2", 0, 3, 5, wc + 1);
   endtask

   task automatic t_other_words;
      int wc;
      log_n = 0;
      bus_wr(BASE + 5*8 + 1, wc);
      bus_wr(BASE + 5*8 + 3, wc);
      bus_wr(BASE + 6*8 + 2, wc);
      bus_wr(BASE + 4*8 + 2, wc);
      idle(4);
      chk(log_n == 0, "R4", "submits from non-trigger words", log_n, 0);
      chk(missed == 8'h00, "R4", "missed after non-trigger words", int'(missed), 0);
   endtask

   task automatic t_disabled;
      int wc;
      map_set(3, 1'b0, 5, 2);
      log_n = 0;
      bus_wr(BASE + 5*8 + 2, wc);
      idle(4);
      chk(log_n == 0, "R3", "submits from disabled channel", log_n, 0);
      map_set(3, 1'b1, 5, 2);
   endtask

   task automatic t_no_enable;
      log_n = 0;
      @(negedge clk);
      bus_wr_waddr = 14'(BASE + 5*8 + 2);
      idle(3);
      bus_wr_waddr = '0;
      idle(3);
      chk(log_n == 0, "R9", "submits with bus_wr_en low", log_n, 0);
   endtask

   task automatic t_multi;
      int wc;
      map_set(6, 1'b1, 100, 7);
      map_set(2, 1'b1, 100, 7);
      map_set(0, 1'b1, 100, 7);
      log_n = 0;
      bus_wr(BASE + 100*8 + 7, wc);
      idle(6);
      chk(log_n == 3, "R5", "shared trigger submit count", log_n, 3);
      if (log_n >= 3) begin
         expect_entry("R5", 0, 0, 100, wc + 1);
         expect_entry("R5", 1, 2, 100, wc + 2);
         expect_entry("R5", 2, 6, 100, wc + 3);
      end
   endtask

   task automatic t_missed;
      int wc;
      map_set(1, 1'b1, 20, 0);
      map_set(4, 1'b1, 20, 0);
      log_n = 0;
      @(negedge clk);
      bus_wr_en = 1'b1; bus_wr_waddr = 14'(BASE + 20*8);
      @(negedge clk);
      wc = cyc;
      @(negedge clk);
      bus_wr_en = 1'b0;
      chk(missed == 8'h10, "R6", "missed after re-trigger", int'(missed), 16);
      idle(6);
      chk(log_n == 3, "R6", "re-trigger submit count", log_n, 3);
      if (log_n >= 3) begin
         expect_entry("R6", 0, 1, 20, wc + 1);
         expect_entry("R6", 1, 1, 20, wc + 2);
         expect_entry("R6", 2, 4, 20, wc + 3);
      end
      chk(missed == 8'h10, "R7", "missed holds while idle", int'(missed), 16);
      @(negedge clk);
      missed_clr = 8'h01;
      @(negedge clk);
      missed_clr = 8'h00;
      chk(missed == 8'h10, "R7", "clear of another bit", int'(missed), 16);
      @(negedge clk);
      missed_clr = 8'h10;
      @(negedge clk);
      missed_clr = 8'h00;
      chk(missed == 8'h00, "R7", "missed after clear", int'(missed), 0);
   endtask

   task automatic t_map_same_edge;
      int wc;
      log_n = 0;
      @(negedge clk);
      map_wr_en = 1'b1; map_wr_chan = 3'd5; map_wr_enable = 1'b1;
      map_wr_entry = 7'd30; map_wr_wsel = 3'd1;
      bus_wr_en = 1'b1; bus_wr_waddr = 14'(BASE + 30*8 + 1);
      @(negedge clk);
      map_wr_en = 1'b0; bus_wr_en = 1'b0;
      idle(4);
      chk(log_n == 0, "R8", "write at map edge uses old map", log_n, 0);
      bus_wr(BASE + 30*8 + 1, wc);
      idle(4);
      chk(log_n == 1, "R8", "write after map edge", log_n, 1);
      if (log_n >= 1) expect_entry("R8", 0, 5, 30, wc + 1);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_single();
      t_other_words();
      t_disabled();
      t_no_enable();
      t_multi();
      t_missed();
      t_map_same_edge();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule